// File: doc/BRIEF.md
# Host-IOP Messaging Queue Unit

This block sits on the controller side of a host adapter. It lets a host and an I/O processor (IOP) pass 32-bit request handles to each other. The host reaches it through a simple 32-bit register bus. Each register access is one strobe cycle, and read data comes back registered one cycle later. The IOP reaches it through a separate set of strobed ports.

Two queue ports carry the traffic, and each one does something different on a read and on a write. A host read of the inbound port hands out a free request offset from a free list. The free list is preloaded at reset. A host write to the inbound port posts a request handle to the IOP. A host read of the outbound port pops a completion that the IOP has posted. A host write to the outbound port gives an IOP-memory offset back to the free list.

The block never interprets a handle. A handle with bit 31 set names a 32-byte aligned host buffer by its bus address shifted right by 5. A handle with bit 31 clear is an offset into IOP memory. A completion is whatever value the IOP pushes, so it may be a context word. Non-queued commands go through message registers. An inbound doorbell, and a status/mask pair for each direction, drive one interrupt towards the host and one towards the IOP.

Top module: `msg_queue_unit`

## Requirements
- R1: After reset the free list holds 16 offsets, 0x1000 + k*0x100 for k = 0..15. Successive host reads of offset 0x40 return them in ascending order.
- R2: A host read strobe yields hst_rvalid and hst_rdata on the following cycle. A read of offset 0x40 or 0x44 while the matching FIFO is empty returns 0xFFFFFFFF.
- R3: A host write to 0x40 posts the handle into a 16-entry FIFO. The IOP sees the handles on iop_post_data in write order with every bit unaltered, including bit 31. Inbound status bit 3 is 1 while that FIFO is not empty.
- R4: A push on iop_cpl_push queues a completion. Host reads of 0x44 return completions in push order. Outbound status bit 3 is 1 while completions remain, and writing 1 to it does not clear it.
- R5: A host write to 0x44 appends the offset to the free list. The IOP may append with iop_free_push when iop_free_rdy is 1. A host write in the same cycle takes the slot and drops iop_free_rdy.
- R6: A write into a full FIFO is dropped and sets sticky bit 4 of the matching status. A full post FIFO sets inbound status. A full free list or a full completion FIFO sets outbound status.
- R7: A host write to 0x10 stores inbound message 0, drives it on iop_imsg0, and sets inbound status bit 0. A write to 0x14 stores inbound message 1 on iop_imsg1 and sets no status.
- R8: An IOP write with iop_omsg_sel=0 stores outbound message 0, which the host reads at 0x18, and sets outbound status bit 0. With sel=1 it stores message 1 at 0x1C and sets no status. Host writes to 0x18 and 0x1C have no effect.
- R9: A host write to 0x20 ORs its bits into the doorbell. iop_db_clr clears bits by writing 1. Inbound status bit 2 is 1 while the doorbell is nonzero.
- R10: Status bits 0 and 4 clear when 1 is written to them: by the host at 0x24 (inbound) or 0x30 (outbound), or by the IOP with iop_istat_clr for inbound status.
- R11: host_irq equals OR(outbound status AND NOT outbound mask), and iop_irq does the same for the inbound status and mask, each one cycle after the status. A mask bit of 1 hides its source. The masks, at 0x28 and 0x34, reset to 0.
- R12: A host read of any offset other than the eleven mapped ones returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | AW | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |
| hst_rvalid | output | 1 | Read data valid, one cycle after hst_rd |
| host_irq | output | 1 | Interrupt to host |
| iop_post_valid | output | 1 | A posted handle is waiting |
| iop_post_data | output | 32 | Oldest posted handle |
| iop_post_pop | input | 1 | IOP consumes the oldest posted handle |
| iop_free_push | input | 1 | IOP returns a free offset |
| iop_free_data | input | 32 | Offset returned by the IOP |
| iop_free_rdy | output | 1 | Free list can take an IOP return this cycle |
| iop_cpl_push | input | 1 | IOP posts a completion |
| iop_cpl_data | input | 32 | Completion value |
| iop_cpl_rdy | output | 1 | Completion FIFO not full |
| iop_imsg0 | output | 32 | Inbound message 0 |
| iop_imsg1 | output | 32 | Inbound message 1 |
| iop_omsg_wr | input | 1 | IOP writes an outbound message |
| iop_omsg_sel | input | 1 | Selects outbound message 0 or 1 |
| iop_omsg_data | input | 32 | Outbound message value |
| iop_doorbell | output | 32 | Current doorbell bits |
| iop_db_clr | input | 32 | Doorbell bits to clear |
| iop_istat_clr | input | 5 | Inbound status bits to clear |
| iop_irq | output | 1 | Interrupt to IOP |

## Verification
On every cycle the assertions check the one-cycle read timing and the all-ones value returned on empty pops. They also check that overflow and the outbound message bit set on the cycle after their cause, that the outbound not-empty bit tracks the completion FIFO, and that host_irq follows the unmasked outbound status. Ordering and data integrity through each FIFO can only be shown by the bench's scenarios. The same holds for the preloaded offsets, for level bits that refuse to clear, for the host's write-ignore on the outbound message registers, and for doorbell set/clear interplay. The bench fills every FIFO to the brim and past it, then drains each one while comparing against values computed arithmetically.

// File: rtl/mqu_pkg.sv
package mqu_pkg;
  localparam logic [7:0] OFS_IMSG0 = 8'h10;
  localparam logic [7:0] OFS_IMSG1 = 8'h14;
  localparam logic [7:0] OFS_OMSG0 = 8'h18;
  localparam logic [7:0] OFS_OMSG1 = 8'h1C;
  localparam logic [7:0] OFS_DBELL = 8'h20;
  localparam logic [7:0] OFS_ISTAT = 8'h24;
  localparam logic [7:0] OFS_IMASK = 8'h28;
  localparam logic [7:0] OFS_OSTAT = 8'h30;
  localparam logic [7:0] OFS_OMASK = 8'h34;
  localparam logic [7:0] OFS_INQ   = 8'h40;
  localparam logic [7:0] OFS_OUTQ  = 8'h44;

  localparam int STW    = 5;
  localparam int SB_MSG = 0;
  localparam int SB_DB  = 2;
  localparam int SB_QNE = 3;
  localparam int SB_OVF = 4;

  localparam logic [STW-1:0] IN_LEVEL_BITS  = 5'b01100;
  localparam logic [STW-1:0] OUT_LEVEL_BITS = 5'b01000;

  localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;
endpackage

// File: rtl/mqu_fifo.sv
module mqu_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  parameter bit PRELOAD = 1'b0,
  parameter logic [W-1:0] BASE = '0,
  parameter logic [W-1:0] STEP = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= PRELOAD ? CW'(DEPTH) : '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  generate
    if (PRELOAD) begin : g_seeded
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= BASE + STEP * W'(i);
        end else if (push_ok) begin
          mem[wptr] <= push_data;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
      end
    end
  endgenerate
endmodule

// File: rtl/mqu_irq_reg.sv
module mqu_irq_reg #(
  parameter int W = 5,
  parameter logic [W-1:0] LEVEL_BITS = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_in,
  input  logic [W-1:0] level_in,
  input  logic [W-1:0] clr_a,
  input  logic [W-1:0] clr_b,
  input  logic         mask_we,
  input  logic [W-1:0] mask_in,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] status_nx;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (LEVEL_BITS[i]) status_nx[i] = level_in[i];
      else status_nx[i] = set_in[i] | (status[i] & ~(clr_a[i] | clr_b[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      if (mask_we) mask <= mask_in;
      irq <= |(status & ~mask);
    end
  end
endmodule

// File: rtl/msg_queue_unit.sv
module msg_queue_unit
  import mqu_pkg::*;
#(
  parameter int AW = 8,
  parameter int QDEPTH = 16,
  parameter logic [31:0] FREE_BASE = 32'h0000_1000,
  parameter logic [31:0] FREE_STEP = 32'h0000_0100
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hst_wr,
  input  logic           hst_rd,
  input  logic [AW-1:0]  hst_addr,
  input  logic [31:0]    hst_wdata,
  output logic [31:0]    hst_rdata,
  output logic           hst_rvalid,
  output logic           host_irq,
  output logic           iop_post_valid,
  output logic [31:0]    iop_post_data,
  input  logic           iop_post_pop,
  input  logic           iop_free_push,
  input  logic [31:0]    iop_free_data,
  output logic           iop_free_rdy,
  input  logic           iop_cpl_push,
  input  logic [31:0]    iop_cpl_data,
  output logic           iop_cpl_rdy,
  output logic [31:0]    iop_imsg0,
  output logic [31:0]    iop_imsg1,
  input  logic           iop_omsg_wr,
  input  logic           iop_omsg_sel,
  input  logic [31:0]    iop_omsg_data,
  output logic [31:0]    iop_doorbell,
  input  logic [31:0]    iop_db_clr,
  input  logic [STW-1:0] iop_istat_clr,
  output logic           iop_irq
);
  // register decode
  logic wr_imsg0, wr_imsg1, wr_db, wr_istat, wr_imask, wr_ostat, wr_omask;
  logic wr_inq, wr_outq, rd_inq, rd_outq;

  assign wr_imsg0 = hst_wr && (hst_addr == AW'(OFS_IMSG0));
  assign wr_imsg1 = hst_wr && (hst_addr == AW'(OFS_IMSG1));
  assign wr_db    = hst_wr && (hst_addr == AW'(OFS_DBELL));
  assign wr_istat = hst_wr && (hst_addr == AW'(OFS_ISTAT));
  assign wr_imask = hst_wr && (hst_addr == AW'(OFS_IMASK));
  assign wr_ostat = hst_wr && (hst_addr == AW'(OFS_OSTAT));
  assign wr_omask = hst_wr && (hst_addr == AW'(OFS_OMASK));
  assign wr_inq   = hst_wr && (hst_addr == AW'(OFS_INQ));
  assign wr_outq  = hst_wr && (hst_addr == AW'(OFS_OUTQ));
  assign rd_inq   = hst_rd && (hst_addr == AW'(OFS_INQ));
  assign rd_outq  = hst_rd && (hst_addr == AW'(OFS_OUTQ));

  // free list: host returns take priority over IOP returns
  logic        free_empty, free_full, free_push;
  logic [31:0] free_head, free_in;

  assign free_push    = wr_outq | (iop_free_push & ~wr_outq);
  assign free_in      = wr_outq ? hst_wdata : iop_free_data;
  assign iop_free_rdy = !free_full && !wr_outq;

  mqu_fifo #(.W(32), .DEPTH(QDEPTH), .PRELOAD(1'b1),
             .BASE(FREE_BASE), .STEP(FREE_STEP)) u_free (
    .clk(clk), .rst(rst), .push(free_push), .push_data(free_in),
    .pop(rd_inq), .head(free_head), .empty(free_empty), .full(free_full)
  );

  // posted requests, host to IOP
  logic post_empty, post_full;

  mqu_fifo #(.W(32), .DEPTH(QDEPTH), .PRELOAD(1'b0),
             .BASE('0), .STEP('0)) u_post (
    .clk(clk), .rst(rst), .push(wr_inq), .push_data(hst_wdata),
    .pop(iop_post_pop), .head(iop_post_data), .empty(post_empty), .full(post_full)
  );
  assign iop_post_valid = !post_empty;

  // completions, IOP to host
  logic        cpl_empty, cpl_full;
  logic [31:0] cpl_head;

  mqu_fifo #(.W(32), .DEPTH(QDEPTH), .PRELOAD(1'b0),
             .BASE('0), .STEP('0)) u_cpl (
    .clk(clk), .rst(rst), .push(iop_cpl_push), .push_data(iop_cpl_data),
    .pop(rd_outq), .head(cpl_head), .empty(cpl_empty), .full(cpl_full)
  );
  assign iop_cpl_rdy = !cpl_full;

  // message and doorbell registers
  logic [31:0] omsg0, omsg1, dbell;

  always_ff @(posedge clk) begin
    if (rst) begin
      iop_imsg0 <= '0;
      iop_imsg1 <= '0;
      omsg0     <= '0;
      omsg1     <= '0;
      dbell     <= '0;
    end else begin
      if (wr_imsg0) iop_imsg0 <= hst_wdata;
      if (wr_imsg1) iop_imsg1 <= hst_wdata;
      if (iop_omsg_wr && !iop_omsg_sel) omsg0 <= iop_omsg_data;
      if (iop_omsg_wr &&  iop_omsg_sel) omsg1 <= iop_omsg_data;
      dbell <= (dbell & ~iop_db_clr) | (wr_db ? hst_wdata : 32'h0);
    end
  end
  assign iop_doorbell = dbell;

  // status, mask and interrupt per direction
  logic [STW-1:0] istat, imask, ostat, omask;
  logic [STW-1:0] in_set, in_lvl, out_set, out_lvl;

  always_comb begin
    in_set          = '0;
    in_set[SB_MSG]  = wr_imsg0;
    in_set[SB_OVF]  = wr_inq && post_full;
    in_lvl          = '0;
    in_lvl[SB_DB]   = (dbell != '0);
    in_lvl[SB_QNE]  = !post_empty;
    out_set         = '0;
    out_set[SB_MSG] = iop_omsg_wr && !iop_omsg_sel;
    out_set[SB_OVF] = (wr_outq && free_full) || (iop_cpl_push && cpl_full);
    out_lvl         = '0;
    out_lvl[SB_QNE] = !cpl_empty;
  end

  mqu_irq_reg #(.W(STW), .LEVEL_BITS(IN_LEVEL_BITS)) u_in_irq (
    .clk(clk), .rst(rst), .set_in(in_set), .level_in(in_lvl),
    .clr_a(wr_istat ? hst_wdata[STW-1:0] : '0), .clr_b(iop_istat_clr),
    .mask_we(wr_imask), .mask_in(hst_wdata[STW-1:0]),
    .status(istat), .mask(imask), .irq(iop_irq)
  );

  mqu_irq_reg #(.W(STW), .LEVEL_BITS(OUT_LEVEL_BITS)) u_out_irq (
    .clk(clk), .rst(rst), .set_in(out_set), .level_in(out_lvl),
    .clr_a(wr_ostat ? hst_wdata[STW-1:0] : '0), .clr_b('0),
    .mask_we(wr_omask), .mask_in(hst_wdata[STW-1:0]),
    .status(ostat), .mask(omask), .irq(host_irq)
  );

  // host read path, registered
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (hst_addr == AW'(OFS_IMSG0)) rd_mux = iop_imsg0;
    if (hst_addr == AW'(OFS_IMSG1)) rd_mux = iop_imsg1;
    if (hst_addr == AW'(OFS_OMSG0)) rd_mux = omsg0;
    if (hst_addr == AW'(OFS_OMSG1)) rd_mux = omsg1;
    if (hst_addr == AW'(OFS_DBELL)) rd_mux = dbell;
    if (hst_addr == AW'(OFS_ISTAT)) rd_mux = 32'(istat);
    if (hst_addr == AW'(OFS_IMASK)) rd_mux = 32'(imask);
    if (hst_addr == AW'(OFS_OSTAT)) rd_mux = 32'(ostat);
    if (hst_addr == AW'(OFS_OMASK)) rd_mux = 32'(omask);
    if (hst_addr == AW'(OFS_INQ))   rd_mux = free_empty ? EMPTY_WORD : free_head;
    if (hst_addr == AW'(OFS_OUTQ))  rd_mux = cpl_empty ? EMPTY_WORD : cpl_head;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata  <= '0;
      hst_rvalid <= 1'b0;
    end else begin
      hst_rvalid <= hst_rd;
      if (hst_rd) hst_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mqu_checker.sv
module mqu_checker
  import mqu_pkg::*;
#(
  parameter int AW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           hst_wr,
  input logic           hst_rd,
  input logic [AW-1:0]  hst_addr,
  input logic [31:0]    hst_rdata,
  input logic           hst_rvalid,
  input logic           host_irq,
  input logic           iop_omsg_wr,
  input logic           iop_omsg_sel,
  input logic           free_empty,
  input logic           post_full,
  input logic           cpl_empty,
  input logic [STW-1:0] istat,
  input logic [STW-1:0] ostat,
  input logic [STW-1:0] omask
);
  // R2: read data arrives one cycle after the strobe
  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    hst_rd |=> hst_rvalid);

  // R2: an empty free list reads as all ones
  a_r2_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && hst_addr == AW'(OFS_INQ) && free_empty) |=> (hst_rdata == EMPTY_WORD));

  // R6: posting into a full FIFO flags inbound overflow
  a_r6_post_overflow: assert property (@(posedge clk) disable iff (rst)
    (hst_wr && hst_addr == AW'(OFS_INQ) && post_full) |=> istat[SB_OVF]);

  // R4: not-empty bit tracks the completion FIFO
  a_r4_cpl_not_empty: assert property (@(posedge clk) disable iff (rst)
    $past(!cpl_empty) |-> ostat[SB_QNE]);

  // R8: outbound message 0 raises its status bit
  a_r8_omsg_status: assert property (@(posedge clk) disable iff (rst)
    (iop_omsg_wr && !iop_omsg_sel) |=> ostat[SB_MSG]);

  // R11: an unmasked source drives host_irq next cycle
  a_r11_irq_on: assert property (@(posedge clk) disable iff (rst)
    ((ostat & ~omask) != '0) |=> host_irq);

  // R11: nothing unmasked means host_irq low next cycle
  a_r11_irq_off: assert property (@(posedge clk) disable iff (rst)
    ((ostat & ~omask) == '0) |=> !host_irq);
endmodule

bind msg_queue_unit mqu_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
  .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid), .host_irq(host_irq),
  .iop_omsg_wr(iop_omsg_wr), .iop_omsg_sel(iop_omsg_sel),
  .free_empty(free_empty), .post_full(post_full), .cpl_empty(cpl_empty),
  .istat(istat), .ostat(ostat), .omask(omask)
);

// File: tb/msg_queue_unit_bench.sv
`timescale 1ns/1ps
module msg_queue_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [7:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        hst_rvalid, host_irq;
  logic        iop_post_valid;
  logic [31:0] iop_post_data;
  logic        iop_post_pop = 1'b0;
  logic        iop_free_push = 1'b0;
  logic [31:0] iop_free_data = '0;
  logic        iop_free_rdy;
  logic        iop_cpl_push = 1'b0;
  logic [31:0] iop_cpl_data = '0;
  logic        iop_cpl_rdy;
  logic [31:0] iop_imsg0, iop_imsg1;
  logic        iop_omsg_wr = 1'b0, iop_omsg_sel = 1'b0;
  logic [31:0] iop_omsg_data = '0;
  logic [31:0] iop_doorbell;
  logic [31:0] iop_db_clr = '0;
  logic [4:0]  iop_istat_clr = '0;
  logic        iop_irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  msg_queue_unit u_msg_queue_unit (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .host_irq(host_irq), .iop_post_valid(iop_post_valid), .iop_post_data(iop_post_data),
    .iop_post_pop(iop_post_pop), .iop_free_push(iop_free_push),
    .iop_free_data(iop_free_data), .iop_free_rdy(iop_free_rdy),
    .iop_cpl_push(iop_cpl_push), .iop_cpl_data(iop_cpl_data), .iop_cpl_rdy(iop_cpl_rdy),
    .iop_imsg0(iop_imsg0), .iop_imsg1(iop_imsg1), .iop_omsg_wr(iop_omsg_wr),
    .iop_omsg_sel(iop_omsg_sel), .iop_omsg_data(iop_omsg_data),
    .iop_doorbell(iop_doorbell), .iop_db_clr(iop_db_clr),
    .iop_istat_clr(iop_istat_clr), .iop_irq(iop_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = a;
    @(negedge clk);
    d = hst_rdata;
    hst_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic cpl_push(input logic [31:0] d);
    @(negedge clk);
    iop_cpl_push = 1'b1; iop_cpl_data = d;
    @(negedge clk);
    iop_cpl_push = 1'b0;
  endtask

  task automatic omsg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    iop_omsg_wr = 1'b1; iop_omsg_sel = sel; iop_omsg_data = d;
    @(negedge clk);
    iop_omsg_wr = 1'b0;
  endtask

  function automatic logic [31:0] post_h(input int i);
    return (i % 2 == 1) ? (32'h8000_0000 | 32'(32'h100 + i)) : 32'(32'h2000 + i * 32'h100);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R11 reset host_irq", 32'(host_irq), 0);
    chk("R11 reset iop_irq", 32'(iop_irq), 0);
    chk("R3 reset post_valid", 32'(iop_post_valid), 0);
    chk("R4 reset cpl_rdy", 32'(iop_cpl_rdy), 1);
    chk("R2 reset rvalid", 32'(hst_rvalid), 0);

    // R12 unmapped read, R2 valid timing
    hrd(8'h08, d);
    chk("R12 unmapped", d, 0);
    chk("R2 rvalid", 32'(hst_rvalid), 1);

    // R1 preloaded free list
    for (int k = 0; k < 16; k++) begin
      hrd(8'h40, d);
      chk("R1 free offset", d, 32'h1000 + 32'(k) * 32'h100);
    end
    hrd(8'h40, d);
    chk("R2 empty free list", d, 32'hFFFF_FFFF);
    hrd(8'h44, d);
    chk("R2 empty completion", d, 32'hFFFF_FFFF);

    // R5 returns to free list, host and IOP
    settle();
    chk("R5 free_rdy", 32'(iop_free_rdy), 1);
    for (int k = 0; k < 15; k++) hwr(8'h44, 32'h1F00 - 32'(k) * 32'h100);
    @(negedge clk);
    iop_free_push = 1'b1; iop_free_data = 32'h000A_BC00;
    @(negedge clk);
    iop_free_push = 1'b0;
    settle();
    chk("R5 free_rdy when full", 32'(iop_free_rdy), 0);
    hwr(8'h44, 32'h5555);
    hrd(8'h30, d);
    chk("R6 free list overflow", d, 32'h10);
    settle();
    chk("R11 overflow irq", 32'(host_irq), 1);
    hwr(8'h30, 32'h10);
    hrd(8'h30, d);
    chk("R10 ostat w1c", d, 0);
    settle();
    chk("R11 irq drop", 32'(host_irq), 0);
    for (int k = 0; k < 15; k++) begin
      hrd(8'h40, d);
      chk("R5 returned order", d, 32'h1F00 - 32'(k) * 32'h100);
    end
    hrd(8'h40, d);
    chk("R5 iop return", d, 32'h000A_BC00);
    hrd(8'h40, d);
    chk("R2 drained free list", d, 32'hFFFF_FFFF);

    // R3 posted requests
    for (int i = 0; i < 16; i++) hwr(8'h40, post_h(i));
    settle();
    chk("R3 post_valid", 32'(iop_post_valid), 1);
    hrd(8'h24, d);
    chk("R3 istat not empty", d, 32'h08);
    chk("R11 iop_irq", 32'(iop_irq), 1);
    hwr(8'h40, 32'hDEAD_BEEF);
    hrd(8'h24, d);
    chk("R6 post overflow", d, 32'h18);
    hwr(8'h24, 32'h18);
    hrd(8'h24, d);
    chk("R10 level bit stays", d, 32'h08);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R3 post valid each", 32'(iop_post_valid), 1);
      chk("R3 post data", iop_post_data, post_h(i));
      iop_post_pop = 1'b1;
      @(negedge clk);
      iop_post_pop = 1'b0;
    end
    settle();
    chk("R3 drained", 32'(iop_post_valid), 0);
    hrd(8'h24, d);
    chk("R3 istat clear", d, 0);
    chk("R11 iop_irq low", 32'(iop_irq), 0);

    // R4 completions
    for (int i = 0; i < 16; i++) cpl_push(32'hC000_0000 + 32'(i) * 32'h3);
    settle();
    chk("R4 cpl_rdy full", 32'(iop_cpl_rdy), 0);
    hrd(8'h30, d);
    chk("R4 ostat not empty", d, 32'h08);
    chk("R11 host_irq", 32'(host_irq), 1);
    hwr(8'h30, 32'h08);
    hrd(8'h30, d);
    chk("R4 qne not clearable", d, 32'h08);
    hwr(8'h34, 32'h1F);
    settle();
    chk("R11 masked", 32'(host_irq), 0);
    hrd(8'h34, d);
    chk("R11 mask readback", d, 32'h1F);
    cpl_push(32'h1234_5678);
    hrd(8'h30, d);
    chk("R6 cpl overflow", d, 32'h18);
    hwr(8'h34, 32'h0);
    for (int i = 0; i < 16; i++) begin
      hrd(8'h44, d);
      chk("R4 cpl order", d, 32'hC000_0000 + 32'(i) * 32'h3);
    end
    hrd(8'h44, d);
    chk("R2 cpl empty", d, 32'hFFFF_FFFF);
    hrd(8'h30, d);
    chk("R4 ovf only", d, 32'h10);
    hwr(8'h30, 32'h10);
    settle();
    chk("R11 host_irq clear", 32'(host_irq), 0);

    // R7 inbound messages
    hwr(8'h10, 32'h00C0_FFEE);
    chk("R7 imsg0", iop_imsg0, 32'h00C0_FFEE);
    hwr(8'h14, 32'h0000_1234);
    chk("R7 imsg1", iop_imsg1, 32'h0000_1234);
    hrd(8'h24, d);
    chk("R7 istat msg", d, 32'h01);
    chk("R7 iop_irq", 32'(iop_irq), 1);
    @(negedge clk);
    iop_istat_clr = 5'h01;
    @(negedge clk);
    iop_istat_clr = 5'h00;
    settle();
    hrd(8'h24, d);
    chk("R10 iop clear", d, 0);
    chk("R10 iop_irq low", 32'(iop_irq), 0);

    // R8 outbound messages
    omsg(1'b0, 32'h0BAD_F00D);
    hrd(8'h18, d);
    chk("R8 omsg0", d, 32'h0BAD_F00D);
    omsg(1'b1, 32'h77);
    hrd(8'h1C, d);
    chk("R8 omsg1", d, 32'h77);
    hrd(8'h30, d);
    chk("R8 ostat msg", d, 32'h01);
    hwr(8'h18, 32'h0);
    hwr(8'h1C, 32'h0);
    hrd(8'h18, d);
    chk("R8 host write ignored 0", d, 32'h0BAD_F00D);
    hrd(8'h1C, d);
    chk("R8 host write ignored 1", d, 32'h77);
    hwr(8'h30, 32'h01);

    // R9 doorbell
    hwr(8'h20, 32'h05);
    hwr(8'h20, 32'h30);
    chk("R9 doorbell or", iop_doorbell, 32'h35);
    hrd(8'h20, d);
    chk("R9 doorbell read", d, 32'h35);
    hrd(8'h24, d);
    chk("R9 istat db", d, 32'h04);
    @(negedge clk);
    iop_db_clr = 32'h05;
    @(negedge clk);
    iop_db_clr = 32'h0;
    chk("R9 partial clear", iop_doorbell, 32'h30);
    hrd(8'h24, d);
    chk("R9 istat db held", d, 32'h04);
    @(negedge clk);
    iop_db_clr = 32'h30;
    @(negedge clk);
    iop_db_clr = 32'h0;
    settle();
    hrd(8'h24, d);
    chk("R9 istat db cleared", d, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule